// File: doc/BRIEF.md
# NMI Re-entry Guard

This block sits between a set of non-maskable event sources and a CPU's active-low NMI input. When any source raises an event while the guard is idle, it drives NMI low for a fixed number of clocks. It then stays busy and passes no further NMI to the CPU until the service routine has handed control back. Without it, a second event could re-enter the handler before its return. That return copies the saved maskable-interrupt enable back, so the outer handler would run with maskable interrupts unmasked.

Software ends the busy period by writing to a dedicated I/O port as the last instruction before its NMI return. The write alone does not re-arm the guard. The guard first counts falling edges of the CPU's opcode-fetch strobe (M1). It re-arms only after the configured number of fetches, which is two by default and covers both fetches of a prefixed return. Events that arrive while busy are not lost: they collapse into one pending request, and that request is delivered at the moment of re-arm.

There is no data stream through the block. All pins are plain control and status signals, sampled synchronously to `clk`.

Top module: `nmi_reentry_guard`

## Requirements
- R1: While `rst_n` is low and after it is released, `nmi_n` is high, `busy` is low, no request is pending and the M1 count is zero.
- R2: In idle, a rising edge (low in the previous sampled cycle, high now) on any `evt_i` bit drives `nmi_n` low from the next clock edge for exactly PULSE_CLKS clocks. `busy` goes high at that same edge.
- R3: While `busy` is high, a new event never pulls `nmi_n` low. A new NMI may begin only from idle or at the re-arm edge.
- R4: Events that arrive while busy set a single pending bit. Any number of them yields exactly one further NMI, and without a pending event no second NMI occurs.
- R5: A release is the first sampled cycle with `io_wr_n` low and `addr_lo` equal to PORT_ADDR. It is honoured only after the NMI pulse has ended while still busy. Writes to other addresses, and releases while idle or during the pulse, have no effect.
- R6: After a release, the guard re-arms at the clock edge that samples the M1_COUNT-th falling edge of `m1_n` (high in the previous sampled cycle, low now). M1 falls seen before the release are not counted. `busy` drops at re-arm when nothing is pending.
- R7: If a request is pending at re-arm, or an event edge arrives in that cycle, `nmi_n` goes low at the re-arm edge and `busy` stays high.
- R8: Rising edges on several sources in the same cycle produce one NMI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_SRC | Event request lines, one per source, active high |
| io_wr_n | input | 1 | CPU I/O write strobe, active low |
| addr_lo | input | 8 | Low byte of the CPU address bus |
| m1_n | input | 1 | CPU opcode-fetch strobe, active low |
| nmi_n | output | 1 | NMI line to the CPU, active low |
| busy | output | 1 | High from NMI assertion until re-arm |

## Verification
On every cycle, the assertions check the following: NMI is low only while the guard is busy; NMI falls only from idle or at re-arm; a pending request exists only while busy; a release lasts a single cycle; and the M1 count stays below its threshold. Other behaviours can only be shown by the bench's scenarios. These are the exact pulse length, the exact M1 edge on which re-arm happens, and the fact that writes to the wrong port or at the wrong time are ignored. The bench also shows that many events during one busy period collapse into exactly one follow-up NMI. A cycle-level reference model in the bench compares both outputs throughout a randomised run.

// File: rtl/nmi_guard_pkg.sv
package nmi_guard_pkg;
  typedef enum logic [1:0] {
    G_IDLE  = 2'd0,
    G_PULSE = 2'd1,
    G_HOLD  = 2'd2,
    G_COUNT = 2'd3
  } guard_state_t;
endpackage

// File: rtl/nmi_src_edge.sv
module nmi_src_edge #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic               fire_o
);
  logic [NUM_SRC-1:0] evt_q;
  logic [NUM_SRC-1:0] rise;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_q[g] <= 1'b0;
      else        evt_q[g] <= evt_i[g];
    end
    assign rise[g] = evt_i[g] & ~evt_q[g];
  end

  assign fire_o = |rise;
endmodule

// File: rtl/nmi_port_decode.sv
module nmi_port_decode #(
  parameter logic [7:0] PORT_ADDR = 8'h3F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_wr_n,
  input  logic [7:0] addr_lo,
  output logic       rel_o
);
  logic match, match_q;

  assign match = !io_wr_n && (addr_lo == PORT_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= match;
  end

  assign rel_o = match & ~match_q;

  // a release strobe lasts one cycle per port write (R5)
  assert_rel_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rel_o |=> !rel_o);
endmodule

// File: rtl/nmi_m1_counter.sv
module nmi_m1_counter #(
  parameter int M1_COUNT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic m1_n,
  input  logic en_i,
  output logic done_o
);
  localparam int CW = (M1_COUNT > 1) ? $clog2(M1_COUNT) : 1;
  localparam logic [CW-1:0] LAST = CW'(M1_COUNT - 1);

  logic          m1_q;
  logic          fall;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) m1_q <= 1'b1;
    else        m1_q <= m1_n;
  end

  assign fall   = m1_q & ~m1_n;
  assign done_o = en_i & fall & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!en_i)          cnt <= '0;
    else if (fall && !done_o) cnt <= cnt + 1'b1;
  end

  // count never passes its threshold (R6)
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  // count is cleared whenever counting is not enabled (R1)
  assert_cnt_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt == '0));
endmodule

// File: rtl/nmi_reentry_guard.sv
module nmi_reentry_guard
  import nmi_guard_pkg::*;
#(
  parameter int         NUM_SRC    = 4,
  parameter logic [7:0] PORT_ADDR  = 8'h3F,
  parameter int         M1_COUNT   = 2,
  parameter int         PULSE_CLKS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               io_wr_n,
  input  logic [7:0]         addr_lo,
  input  logic               m1_n,
  output logic               nmi_n,
  output logic               busy
);
  localparam int PCW = (PULSE_CLKS > 1) ? $clog2(PULSE_CLKS) : 1;
  localparam logic [PCW-1:0] PLAST = PCW'(PULSE_CLKS - 1);

  guard_state_t   state, state_nx;
  logic [PCW-1:0] pcnt;
  logic           pend;
  logic           fire, rel, rearm;

  nmi_src_edge #(.NUM_SRC(NUM_SRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .fire_o(fire)
  );

  nmi_port_decode #(.PORT_ADDR(PORT_ADDR)) u_port (
    .clk(clk), .rst_n(rst_n), .io_wr_n(io_wr_n), .addr_lo(addr_lo), .rel_o(rel)
  );

  nmi_m1_counter #(.M1_COUNT(M1_COUNT)) u_m1 (
    .clk(clk), .rst_n(rst_n), .m1_n(m1_n),
    .en_i(state == G_COUNT), .done_o(rearm)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      G_IDLE:  if (fire) state_nx = G_PULSE;
      G_PULSE: if (pcnt == PLAST) state_nx = G_HOLD;
      G_HOLD:  if (rel) state_nx = G_COUNT;
      G_COUNT: if (rearm) state_nx = (pend || fire) ? G_PULSE : G_IDLE;
      default: state_nx = G_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= G_IDLE;
      pcnt  <= '0;
      pend  <= 1'b0;
    end else begin
      state <= state_nx;
      if (state == G_PULSE) pcnt <= pcnt + 1'b1;
      else                  pcnt <= '0;
      if (rearm)                          pend <= 1'b0;
      else if (fire && state != G_IDLE)   pend <= 1'b1;
    end
  end

  assign nmi_n = (state != G_PULSE);
  assign busy  = (state != G_IDLE);

  // NMI is only driven while busy (R2)
  assert_nmi_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_n |-> busy);
  // becoming busy always starts with NMI asserted (R2)
  assert_busy_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !nmi_n);
  // no re-entry: NMI falls only from idle or at re-arm (R3)
  assert_no_reentry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nmi_n) |-> ($past(state) == G_IDLE || $past(state) == G_COUNT));
  // a pending request exists only while busy (R4)
  assert_pend_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> busy);
endmodule

// File: tb/nmi_reentry_guard_tb.sv
`timescale 1ns/1ps
module nmi_reentry_guard_tb;
  localparam int         NS   = 4;
  localparam logic [7:0] PORT = 8'h3F;
  localparam int         M1C  = 2;
  localparam int         PC   = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] evt_i = '0;
  logic          io_wr_n = 1'b1;
  logic [7:0]    addr_lo = '0;
  logic          m1_n = 1'b1;
  logic          nmi_n, busy;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  nmi_reentry_guard #(.NUM_SRC(NS), .PORT_ADDR(PORT), .M1_COUNT(M1C), .PULSE_CLKS(PC)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .io_wr_n(io_wr_n),
    .addr_lo(addr_lo), .m1_n(m1_n), .nmi_n(nmi_n), .busy(busy)
  );

  // reference model built from the requirements
  int      ms, mp, mm;
  bit      mpend, mm1q, mmatq;
  bit [NS-1:0] mevq;

  function automatic bit exp_nmi_n(int s); return s != 1; endfunction
  function automatic bit exp_busy(int s);  return s != 0; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; mp = 0; mm = 0; mpend = 0; mm1q = 1; mmatq = 0; mevq = '0;
    end else begin
      bit fire, match, rel, fall, rearm;
      int old;
      fire  = |(evt_i & ~mevq);
      match = !io_wr_n && addr_lo == PORT;
      rel   = match && !mmatq;
      fall  = !m1_n && mm1q;
      old   = ms;
      rearm = (old == 3) && fall && (mm == M1C - 1);
      case (old)
        0: if (fire) begin ms = 1; mp = 0; end
        1: if (mp == PC - 1) ms = 2; else mp++;
        2: if (rel) begin ms = 3; mm = 0; end
        3: if (rearm) begin
             if (mpend || fire) begin ms = 1; mp = 0; end else ms = 0;
           end else if (fall) mm++;
        default: ms = 0;
      endcase
      if (rearm) mpend = 0;
      else if (fire && old != 0) mpend = 1;
      mevq = evt_i; mm1q = m1_n; mmatq = match;
    end
  end

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic port_write(logic [7:0] a);
    io_wr_n = 1'b0; addr_lo = a; tick();
    io_wr_n = 1'b1; tick();
  endtask

  task automatic m1_fetch();
    m1_n = 1'b0; tick();
    m1_n = 1'b1; tick();
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(2);
    check("R1 reset nmi_n", nmi_n, 1'b1);
    check("R1 reset busy", busy, 1'b0);
    rst_n = 1'b1;
    tick(2);
    check("R1 after reset busy", busy, 1'b0);

    // R2: single event, exact pulse length
    evt_i = 4'b0001; tick(); evt_i = '0;
    check("R2 nmi low", nmi_n, 1'b0);
    check("R2 busy high", busy, 1'b1);
    for (int i = 1; i < PC; i++) begin tick(); check("R2 nmi held", nmi_n, 1'b0); end
    tick();
    check("R2 pulse ended", nmi_n, 1'b1);
    check("R2 still busy", busy, 1'b1);

    // R3: event while busy, no new NMI
    evt_i = 4'b0010; tick(); evt_i = '0; tick();
    check("R3 no reentry", nmi_n, 1'b1);
    // R5: wrong address ignored
    port_write(PORT ^ 8'h01);
    m1_fetch(); m1_fetch(); m1_fetch();
    check("R5 wrong port busy", busy, 1'b1);
    // R6/R7: release, count M1, pending delivered
    port_write(PORT);
    m1_n = 1'b0; tick();
    check("R6 early busy", busy, 1'b1);
    m1_n = 1'b1; tick();
    m1_n = 1'b0; tick();
    check("R7 pending nmi", nmi_n, 1'b0);
    check("R7 busy kept", busy, 1'b1);
    m1_n = 1'b1; tick(PC);
    check("R7 pulse ended", nmi_n, 1'b1);
    port_write(PORT); m1_fetch();
    m1_n = 1'b0; tick();
    check("R6 rearm busy", busy, 1'b0);
    check("R6 rearm nmi", nmi_n, 1'b1);
    m1_n = 1'b1; tick();

    // R5: write while idle ignored; R6: M1 before release not counted
    port_write(PORT); m1_fetch(); m1_fetch();
    check("R5 idle write busy", busy, 1'b0);
    evt_i = 4'b0100; tick(); evt_i = '0;
    check("R5 event after idle write", nmi_n, 1'b0);
    tick(PC + 1);
    m1_fetch(); m1_fetch(); m1_fetch();
    check("R6 no release busy", busy, 1'b1);
    port_write(PORT); m1_fetch(); m1_fetch();
    check("R6 released", busy, 1'b0);
    check("R4 no spurious nmi", nmi_n, 1'b1);

    // R8: simultaneous sources give one NMI
    evt_i = 4'b1111; tick(); evt_i = '0;
    check("R8 nmi low", nmi_n, 1'b0);
    tick(PC + 1);
    port_write(PORT); m1_fetch(); m1_fetch();
    check("R8 single nmi", busy, 1'b0);

    // R4: many events while busy collapse to one
    evt_i = 4'b1011; tick(); evt_i = '0;
    evt_i = 4'b1000; tick(); evt_i = '0; tick();
    evt_i = 4'b0001; tick(); evt_i = '0;
    tick(PC);
    evt_i = 4'b0100; tick(); evt_i = '0; tick();
    port_write(PORT); m1_fetch();
    m1_n = 1'b0; tick();
    check("R4 pending nmi", nmi_n, 1'b0);
    m1_n = 1'b1; tick(PC + 1);
    port_write(PORT); m1_fetch(); m1_fetch();
    check("R4 collapsed busy", busy, 1'b0);
    check("R4 collapsed nmi", nmi_n, 1'b1);

    // randomised run compared with the reference model (R2 R3 R4 R5 R6 R7)
    void'($urandom(32'd4242));
    for (int c = 0; c < 6000; c++) begin
      check("R3 model nmi_n", nmi_n, exp_nmi_n(ms));
      check("R6 model busy", busy, exp_busy(ms));
      evt_i   = ($urandom % 12 == 0) ? NS'($urandom) : '0;
      io_wr_n = ($urandom % 6 != 0);
      addr_lo = ($urandom % 3 != 0) ? PORT : 8'($urandom);
      m1_n    = ($urandom % 3 != 0);
      tick();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule